// File: doc/BRIEF.md
# Debug Trace Data Serializer

The block turns capture-worthy events from a processor core into a stream of 4-bit trace nibbles. It watches two event sources. The first is a memory access, which carries a direction, an operand size and 32 data bits. The second is a taken branch, which carries a 32-bit target address. Two static control fields decide what is kept. The capture mode selects which access directions are traced. The branch byte count selects how many low bytes of a branch target are traced.

Each kept event becomes an item that holds its data and a nibble count. Items wait in a small queue. A shifter then emits each item one nibble per clock, starting with the least significant nibble. Items queued behind one another leave with no idle cycle between them. If an event arrives while the queue has no room, the event is dropped and a one-cycle overflow pulse is raised.

Top module: `trace_serializer`

## Requirements
- R1: While `rst_ni` is low and after it is released, `trace_vld_o`, `busy_o` and `overflow_o` are 0 until an event is captured.
- R2: `cap_mode_i` selects which accesses are captured: 00 captures none, 01 captures writes (`mem_write_i`=1), 10 captures reads, 11 captures both. An access that is not captured produces no nibble.
- R3: `mem_size_i` sets the number of nibbles: 00 (byte) gives 2, 01 (word) gives 4, 10 (long) gives 8. The value 11 is reserved and the access produces no output.
- R4: The nibbles of an item leave on consecutive cycles, least significant nibble first: nibble j is bits [4j+3:4j] of the data.
- R5: `br_bytes_i` sets the output of a taken branch: 00 gives nothing, 01 gives the low 2 bytes (4 nibbles), 10 the low 3 bytes (6 nibbles), 11 all 4 bytes (8 nibbles).
- R6: When an event is sampled at a clock edge and the block is idle, its first nibble is valid after the next clock edge.
- R7: Up to 4 items wait in the queue. When the queue has no room, the event is dropped and `overflow_o` is high for exactly the one cycle after the edge that sampled it. The items already queued are not affected.
- R8: When a memory access and a branch are sampled at the same edge, the access's nibbles leave before the branch's nibbles.
- R9: `trace_vld_o` is high only on cycles that carry a nibble. `trace_nib_o` is 0 whenever `trace_vld_o` is low.
- R10: `busy_o` is high whenever a nibble is being sent or an item is waiting, and it returns to 0 once the last nibble has left.
- R11: Queued items are emitted back to back. The first nibble of the next item follows the last nibble of the current item with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_mode_i | input | 2 | Access capture mode |
| br_bytes_i | input | 2 | Branch target byte count code |
| mem_valid_i | input | 1 | A memory access occurs this cycle |
| mem_write_i | input | 1 | 1 for a write, 0 for a read |
| mem_size_i | input | 2 | Operand size code |
| mem_data_i | input | 32 | Access data |
| br_valid_i | input | 1 | A taken branch occurs this cycle |
| br_target_i | input | 32 | Branch target address |
| trace_nib_o | output | 4 | Trace nibble |
| trace_vld_o | output | 1 | Nibble valid |
| busy_o | output | 1 | Sending or items waiting |
| overflow_o | output | 1 | One-cycle pulse when an event is dropped |

## Verification
The assertions check, on every cycle, the local rules of the design. The queue never holds more than its depth. An overflow pulse follows only a sampled event that met an almost-full queue. The shifter moves down one nibble per cycle and counts down without reloading mid-item. No item with a zero nibble count is ever loaded.

Only the bench scenarios can show the end-to-end behaviour. The filter and size encodings are swept over every combination and checked against the nibble stream. The scenarios also cover the exact first-nibble latency, the memory-before-branch order for simultaneous events, the dropping of the fifth waiting event, and the gap-free joining of queued items.

// File: rtl/trace_ser_pkg.sv
package trace_ser_pkg;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned NIB_W    = 4;
  parameter int unsigned NIBS_MAX = DATA_W / NIB_W;
  parameter int unsigned CNT_W    = $clog2(NIBS_MAX + 1);

  typedef enum logic [1:0] {
    CAP_NONE = 2'b00,
    CAP_WR   = 2'b01,
    CAP_RD   = 2'b10,
    CAP_ALL  = 2'b11
  } cap_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } op_size_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  nibs;
  } trace_item_t;
endpackage

// File: rtl/ts_event_filter.sv
module ts_event_filter
  import trace_ser_pkg::*;
(
  input  logic [1:0]        cap_mode_i,
  input  logic [1:0]        br_bytes_i,
  input  logic              mem_valid_i,
  input  logic              mem_write_i,
  input  logic [1:0]        mem_size_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              br_valid_i,
  input  logic [DATA_W-1:0] br_target_i,
  output logic              mem_push_o,
  output trace_item_t       mem_item_o,
  output logic              br_push_o,
  output trace_item_t       br_item_o
);
  logic             dir_ok;
  logic [CNT_W-1:0] mem_nibs;
  logic [CNT_W-1:0] br_nibs;

  always_comb begin
    unique case (cap_mode_e'(cap_mode_i))
      CAP_NONE: dir_ok = 1'b0;
      CAP_WR:   dir_ok = mem_write_i;
      CAP_RD:   dir_ok = ~mem_write_i;
      default:  dir_ok = 1'b1;
    endcase
  end

  // operand bits / nibble width; reserved size yields zero
  always_comb begin
    unique case (op_size_e'(mem_size_i))
      SZ_BYTE: mem_nibs = CNT_W'(8 / NIB_W);
      SZ_WORD: mem_nibs = CNT_W'(16 / NIB_W);
      SZ_LONG: mem_nibs = CNT_W'(32 / NIB_W);
      default: mem_nibs = '0;
    endcase
  end

  // code n>0 selects n+1 low bytes
  always_comb begin
    if (br_bytes_i == 2'b00) br_nibs = '0;
    else br_nibs = CNT_W'((32'(br_bytes_i) + 32'd1) * 8 / NIB_W);
  end

  assign mem_push_o      = mem_valid_i && dir_ok && (mem_nibs != '0);
  assign mem_item_o.data = mem_data_i;
  assign mem_item_o.nibs = mem_nibs;
  assign br_push_o       = br_valid_i && (br_nibs != '0);
  assign br_item_o.data  = br_target_i;
  assign br_item_o.nibs  = br_nibs;
endmodule

// File: rtl/ts_trace_fifo.sv
module ts_trace_fifo
  import trace_ser_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_a_i,
  input  trace_item_t item_a_i,
  input  logic        push_b_i,
  input  trace_item_t item_b_i,
  input  logic        pop_i,
  output trace_item_t head_o,
  output logic        empty_o,
  output logic        overflow_o
);
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W  = $clog2(DEPTH + 1);

  trace_item_t      mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_b_ptr;
  logic [OCC_W-1:0] occ_q, free;
  logic             acc_a, acc_b, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // no credit taken for a same-cycle pop
  assign free     = OCC_W'(DEPTH) - occ_q;
  assign acc_a    = push_a_i && (free != '0);
  assign acc_b    = push_b_i && (free > (acc_a ? OCC_W'(1) : OCC_W'(0)));
  assign drop     = (push_a_i && !acc_a) || (push_b_i && !acc_b);
  assign wr_b_ptr = acc_a ? ptr_inc(wr_q) : wr_q;

  always_ff @(posedge clk_i) begin
    if (acc_a) mem_q[wr_q]     <= item_a_i;
    if (acc_b) mem_q[wr_b_ptr] <= item_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q       <= '0;
      rd_q       <= '0;
      occ_q      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (acc_b)      wr_q <= ptr_inc(wr_b_ptr);
      else if (acc_a) wr_q <= ptr_inc(wr_q);
      if (pop_i) rd_q <= ptr_inc(rd_q);
      occ_q      <= occ_q + OCC_W'(acc_a) + OCC_W'(acc_b) - OCC_W'(pop_i);
      overflow_o <= drop;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (occ_q == '0);

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OCC_W'(DEPTH)); // R7
  AST_OVF_NEAR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> ($past(occ_q) >= OCC_W'(DEPTH - 1))); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (occ_q != '0)); // R11
endmodule

// File: rtl/ts_nibble_shifter.sv
module ts_nibble_shifter
  import trace_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             empty_i,
  input  trace_item_t      head_i,
  output logic             pop_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             vld_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  // reload on the last nibble so items join without a gap
  assign pop_o = !empty_i && (left_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (pop_o) begin
      sh_q   <= head_i.data;
      left_q <= head_i.nibs;
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> NIB_W;
      left_q <= left_q - 1'b1;
    end
  end

  assign vld_o = (left_q != '0);
  assign nib_o = vld_o ? sh_q[NIB_W-1:0] : '0;

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q > CNT_W'(1)) |=> (sh_q[NIB_W-1:0] == $past(sh_q[2*NIB_W-1:NIB_W]))); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q > CNT_W'(1)) |=> (left_q == $past(left_q) - 1'b1)); // R11
  AST_NO_EMPTY_ITEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (head_i.nibs != '0)); // R5
endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
  import trace_ser_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  cap_mode_i,
  input  logic [1:0]  br_bytes_i,
  input  logic        mem_valid_i,
  input  logic        mem_write_i,
  input  logic [1:0]  mem_size_i,
  input  logic [31:0] mem_data_i,
  input  logic        br_valid_i,
  input  logic [31:0] br_target_i,
  output logic [3:0]  trace_nib_o,
  output logic        trace_vld_o,
  output logic        busy_o,
  output logic        overflow_o
);
  logic        mem_push, br_push, pop, empty;
  trace_item_t mem_item, br_item, head;

  ts_event_filter u_filter (
    .cap_mode_i  (cap_mode_i),
    .br_bytes_i  (br_bytes_i),
    .mem_valid_i (mem_valid_i),
    .mem_write_i (mem_write_i),
    .mem_size_i  (mem_size_i),
    .mem_data_i  (mem_data_i),
    .br_valid_i  (br_valid_i),
    .br_target_i (br_target_i),
    .mem_push_o  (mem_push),
    .mem_item_o  (mem_item),
    .br_push_o   (br_push),
    .br_item_o   (br_item)
  );

  // port a takes the access so it precedes a same-cycle branch
  ts_trace_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_a_i   (mem_push),
    .item_a_i   (mem_item),
    .push_b_i   (br_push),
    .item_b_i   (br_item),
    .pop_i      (pop),
    .head_o     (head),
    .empty_o    (empty),
    .overflow_o (overflow_o)
  );

  ts_nibble_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (empty),
    .head_i  (head),
    .pop_o   (pop),
    .nib_o   (trace_nib_o),
    .vld_o   (trace_vld_o)
  );

  assign busy_o = trace_vld_o || !empty;

  AST_OVF_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(mem_valid_i || br_valid_i)); // R7
  AST_IDLE_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mem_valid_i && !br_valid_i) |=> !trace_vld_o); // R10
endmodule

// File: tb/trace_serializer_bench.sv
module trace_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00, bytes = 2'b00, msz = 2'b00;
  logic        mv = 1'b0, mw = 1'b0, bv = 1'b0;
  logic [31:0] md = '0, bt = '0;
  logic [3:0]  nib;
  logic        vld, busy, ovf;

  int checks = 0, errors = 0, cyc = 0, ev_cyc = 0;
  int nib_bad = 0, busy_bad = 0;
  logic [3:0] cap[$];
  int         stamp[$];
  logic [3:0] exp_q[$];

  always #10ns clk = ~clk;

  trace_serializer u_trace_serializer (
    .clk_i(clk), .rst_ni(rst_n), .cap_mode_i(mode), .br_bytes_i(bytes),
    .mem_valid_i(mv), .mem_write_i(mw), .mem_size_i(msz), .mem_data_i(md),
    .br_valid_i(bv), .br_target_i(bt), .trace_nib_o(nib), .trace_vld_o(vld),
    .busy_o(busy), .overflow_o(ovf));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (vld) begin cap.push_back(nib); stamp.push_back(cyc); end
    else if (nib != 4'h0) nib_bad++;
    if (vld && !busy) busy_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic add_exp(input logic [31:0] d, input int n);
    for (int j = 0; j < n; j++) exp_q.push_back(d[4*j +: 4]);
  endtask

  task automatic event_pulse(input logic m_v, input logic m_w, input logic [1:0] m_sz,
                             input logic [31:0] m_d, input logic b_v, input logic [31:0] b_t);
    cap.delete(); stamp.delete();
    @(negedge clk);
    mv = m_v; mw = m_w; msz = m_sz; md = m_d; bv = b_v; bt = b_t;
    @(negedge clk);
    ev_cyc = cyc;
    mv = 1'b0; bv = 1'b0;
  endtask

  task automatic compare_stream(input string req);
    logic ok;
    chk(req, cap.size(), exp_q.size());
    ok = (cap.size() == exp_q.size());
    if (ok) foreach (exp_q[i]) if (cap[i] !== exp_q[i]) ok = 1'b0;
    chk(req, ok, 1'b1);
    if (exp_q.size() > 0 && cap.size() > 0)
      chk("R6", stamp[0], ev_cyc + 1);
    exp_q.delete();
  endtask

  initial begin
    #(20ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    chk("R1", {vld, busy, ovf}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {vld, busy, ovf, nib}, 7'd0);

    // R2 R3 R4: every mode x direction x size
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++) begin
          mode = 2'(m);
          d = 32'h9ABC_DE1F + 32'(m * 8 + w * 4 + s) * 32'h0513_7C29;
          n = ((w == 1) ? m[0] : m[1]) && s != 3 ? (2 << s) : 0;
          add_exp(d, n);
          event_pulse(1'b1, 1'(w), 2'(s), d, 1'b0, '0);
          repeat (11) @(negedge clk);
          chk("R10", busy, 1'b0);
          compare_stream(n == 0 ? "R2" : "R3");
        end

    // R5: branch byte counts
    for (int b = 0; b < 4; b++) begin
      bytes = 2'(b);
      d = 32'h3F28_A6D7 ^ 32'(b * 32'h1111_1111);
      n = (b == 0) ? 0 : 2 * (b + 1);
      add_exp(d, n);
      event_pulse(1'b0, 1'b0, 2'b00, '0, 1'b1, d);
      repeat (11) @(negedge clk);
      compare_stream("R5");
    end

    // R8: access and branch at the same edge
    mode = 2'b11; bytes = 2'b01;
    add_exp(32'h0000_C3B5, 4);
    add_exp(32'h1234_5E6A, 4);
    event_pulse(1'b1, 1'b0, 2'b01, 32'h0000_C3B5, 1'b1, 32'h1234_5E6A);
    repeat (14) @(negedge clk);
    compare_stream("R8");
    chk("R11", stamp[stamp.size()-1] - stamp[0] + 1, 8);

    // R7: fifth waiting event is dropped
    bytes = 2'b11;
    cap.delete(); stamp.delete();
    @(negedge clk);
    mv = 1'b1; mw = 1'b1; msz = 2'b10; md = 32'hF1E2_D3C4;
    add_exp(32'hF1E2_D3C4, 8);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 1) ev_cyc = cyc;
      chk("R7", ovf, 1'b0);
      mv = 1'b0; bv = 1'b1; bt = 32'h2468_ACE0 + 32'(i * 32'h0101_0101);
      if (i < 5) add_exp(bt, 8);
    end
    @(negedge clk);
    bv = 1'b0;
    chk("R7", ovf, 1'b1);
    @(negedge clk);
    chk("R7", ovf, 1'b0);
    repeat (45) @(negedge clk);
    compare_stream("R7");
    chk("R11", stamp[stamp.size()-1] - stamp[0] + 1, 40);
    chk("R10", busy, 1'b0);

    chk("R9", nib_bad, 0);
    chk("R10", busy_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule